// File: doc/BRIEF.md
# Fetch Control-Flow Predictor

This block sits beside the fetch stage of an in-order 32-bit RISC-V core. Each cycle it looks at the fetched instruction word and its address and decides where fetch goes next. A small decoder picks out conditional branches, direct jumps, calls and returns.

Direct jumps are redirected at once, using their own adder to form address plus offset. Returns take their target from a short stack of return addresses, which calls fill. Conditional branches are predicted from two structures kept apart: a table of two-bit saturating counters gives the direction, and a tagged target buffer gives the destination.

The execute stage trains both structures through an update port that carries the resolved branch address, its outcome and its target. The prediction is combinational on the fetch inputs. Stack and table state change on the following clock edge.

Top module: `fe_flow_predictor`

## Requirements
- R1: With fetch valid and opcode bits [6:0] = 1101111 (direct jump), the block predicts taken in the same cycle, with target = fetch PC + sign-extended J-immediate (instr[31] as bit 20, instr[19:12], instr[20] as bit 11, instr[30:21] as bits 10:1, bit 0 zero).
- R2: A call is a direct jump or an indirect jump (opcode 1100111) whose rd field (instr[11:7]) is 1 or 5. It pushes fetch PC + 4 onto the return stack. An indirect call is predicted not-taken, with target PC + 4.
- R3: A return is opcode 1100111 with rd = 0 and rs1 (instr[19:15]) equal to 1 or 5. With a non-empty stack it is predicted taken, its target is the most recently pushed address, and that entry is popped.
- R4: A return with an empty stack is predicted not-taken, with target PC + 4, and leaves the stack empty.
- R5: The stack holds RAS_DEPTH entries (default 2). A push onto a full stack discards the oldest entry, so after three calls two returns yield the third and the second call's addresses and a third return finds the stack empty.
- R6: A conditional branch (opcode 1100011) is predicted taken only when its counter, indexed by PC bits [5:2], is 2 or 3 and the target buffer entry at PC bits [4:2] is valid with a tag equal to PC bits [31:5]. The predicted target is the stored target, not the instruction's own offset.
- R7: Counters reset to 1. An update with outcome taken increments the counter at the update PC, and outcome not-taken decrements it, saturating at 3 and at 0.
- R8: The target buffer is written only on taken updates and holds one target per slot. A branch whose slot is invalid or whose tag does not match is predicted not-taken, even when its counter says taken.
- R9: With fetch valid low, the prediction is not-taken, with target PC + 4, and the stack is left unchanged. After reset the stack is empty.
- R10: Any other instruction word, including an indirect jump that is neither a call nor a return, is predicted not-taken with target PC + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetched word is valid this cycle |
| fetch_pc_i | input | PC_W | Address of the fetched word |
| fetch_instr_i | input | 32 | Fetched instruction word |
| upd_valid_i | input | 1 | Resolved conditional branch from execute |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome of the resolved branch |
| upd_target_i | input | PC_W | Actual target of the resolved branch |
| pred_taken_o | output | 1 | Predicted redirect |
| pred_target_o | output | PC_W | Predicted next fetch address (PC + 4 when not taken) |

## Verification
The bound checker covers these rules on every cycle:
- a direct jump is always taken;
- any not-taken prediction points to PC + 4;
- idle fetch neither redirects nor moves the stack;
- a call grows the stack by one until it is full;
- a return on an empty stack falls through;
- a return on a non-empty stack redirects and shrinks the stack;
- the stack count never exceeds its depth.

Some behaviour appears only in the bench's scenarios, because it depends on history across many cycles:
- the return address values and their last-in-first-out order;
- the loss of the oldest entry on overflow;
- counter saturation at both ends;
- the handover of a target buffer slot between two branches that share it.

// File: rtl/fe_pred_pkg.sv
package fe_pred_pkg;

   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;

   typedef enum logic [1:0] {
      CF_NONE,
      CF_BRANCH,
      CF_JUMP,
      CF_INDIRECT
   } cf_kind_e;

   // link registers used by the calling convention (ra and t0)
   function automatic logic is_link_reg(input logic [4:0] r);
      return (r == 5'd1) || (r == 5'd5);
   endfunction

endpackage

// File: rtl/fe_predecode.sv
module fe_predecode
   import fe_pred_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic [31:0]     instr_i,
   output cf_kind_e        kind_o,
   output logic            is_call_o,
   output logic            is_ret_o,
   output logic [PC_W-1:0] jump_off_o
);

   logic [6:0]         opc;
   logic [4:0]         rd;
   logic [4:0]         rs1;
   logic signed [20:0] jimm;

   assign opc  = instr_i[6:0];
   assign rd   = instr_i[11:7];
   assign rs1  = instr_i[19:15];
   assign jimm = {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};

   always_comb begin
      unique case (opc)
         OPC_JAL:    kind_o = CF_JUMP;
         OPC_JALR:   kind_o = CF_INDIRECT;
         OPC_BRANCH: kind_o = CF_BRANCH;
         default:    kind_o = CF_NONE;
      endcase
   end

   assign is_call_o  = ((kind_o == CF_JUMP) || (kind_o == CF_INDIRECT)) && is_link_reg(rd);
   assign is_ret_o   = (kind_o == CF_INDIRECT) && (rd == 5'd0) && is_link_reg(rs1);
   assign jump_off_o = PC_W'(jimm);

endmodule

// File: rtl/fe_counter_table.sv
module fe_counter_table #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             rd_taken_o,
   input  logic             upd_en_i,
   input  logic [IDX_W-1:0] upd_idx_i,
   input  logic             upd_taken_i
);

   logic [1:0] ctr_all [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
      logic [1:0] ctr_q;
      logic       hit;

      assign hit = upd_en_i && (upd_idx_i == IDX_W'(g));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ctr_q <= 2'd1;
         end else if (hit) begin
            if (upd_taken_i && ctr_q != 2'd3) begin
               ctr_q <= ctr_q + 2'd1;
            end else if (!upd_taken_i && ctr_q != 2'd0) begin
               ctr_q <= ctr_q - 2'd1;
            end
         end
      end

      assign ctr_all[g] = ctr_q;
   end

   assign rd_taken_o = ctr_all[rd_idx_i][1];

endmodule

// File: rtl/fe_target_buffer.sv
module fe_target_buffer #(
   parameter int PC_W    = 32,
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 27,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [IDX_W-1:0] lk_idx_i,
   input  logic [TAG_W-1:0] lk_tag_i,
   output logic             lk_hit_o,
   output logic [PC_W-1:0]  lk_target_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic [PC_W-1:0]  wr_target_i
);

   logic             valid_q  [ENTRIES];
   logic [TAG_W-1:0] tag_q    [ENTRIES];
   logic [PC_W-1:0]  target_q [ENTRIES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
      end else if (wr_en_i) begin
         valid_q[wr_idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         tag_q[wr_idx_i]    <= wr_tag_i;
         target_q[wr_idx_i] <= wr_target_i;
      end
   end

   assign lk_hit_o    = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
   assign lk_target_o = target_q[lk_idx_i];

endmodule

// File: rtl/fe_ras.sv
module fe_ras #(
   parameter int PC_W   = 32,
   parameter int DEPTH  = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [PC_W-1:0]  push_addr_i,
   input  logic             pop_i,
   output logic [PC_W-1:0]  top_o,
   output logic [CNT_W-1:0] count_o
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (push_i) begin
         if (count_q != CNT_W'(DEPTH)) count_q <= count_q + 1'b1;
      end else if (pop_i && count_q != '0) begin
         count_q <= count_q - 1'b1;
      end
   end

   if (DEPTH == 1) begin : g_single
      logic [PC_W-1:0] slot_q;
      always_ff @(posedge clk_i) begin
         if (push_i) slot_q <= push_addr_i;
      end
      assign top_o = slot_q;
   end else begin : g_shift
      // slot 0 is the top; the last slot falls off on overflow
      logic [PC_W-1:0] slot_q [DEPTH];
      always_ff @(posedge clk_i) begin
         if (push_i) begin
            slot_q[0] <= push_addr_i;
            for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_q[i-1];
         end else if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) slot_q[i] <= slot_q[i+1];
         end
      end
      assign top_o = slot_q[0];
   end

   assign count_o = count_q;

endmodule

// File: rtl/fe_flow_predictor.sv
module fe_flow_predictor
   import fe_pred_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int BHT_ENTRIES = 16,
   parameter int BTB_ENTRIES = 8,
   parameter int RAS_DEPTH   = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            fetch_valid_i,
   input  logic [PC_W-1:0] fetch_pc_i,
   input  logic [31:0]     fetch_instr_i,
   input  logic            upd_valid_i,
   input  logic [PC_W-1:0] upd_pc_i,
   input  logic            upd_taken_i,
   input  logic [PC_W-1:0] upd_target_i,
   output logic            pred_taken_o,
   output logic [PC_W-1:0] pred_target_o
);

   localparam int BHT_IW = $clog2(BHT_ENTRIES);
   localparam int BTB_IW = $clog2(BTB_ENTRIES);
   localparam int TAG_W  = PC_W - BTB_IW - 2;
   localparam int RAS_CW = $clog2(RAS_DEPTH + 1);

   if (PC_W < 21 || PC_W > 64) begin : g_bad_pc_w
      $error("PC_W must lie in 21..64");
   end
   if (BHT_ENTRIES < 2 || (1 << BHT_IW) != BHT_ENTRIES) begin : g_bad_bht
      $error("BHT_ENTRIES must be a power of two of at least 2");
   end
   if (BTB_ENTRIES < 2 || (1 << BTB_IW) != BTB_ENTRIES) begin : g_bad_btb
      $error("BTB_ENTRIES must be a power of two of at least 2");
   end
   if (BHT_IW + 2 > PC_W || TAG_W < 1) begin : g_bad_idx
      $error("table index does not fit in the PC");
   end
   if (RAS_DEPTH < 1) begin : g_bad_ras
      $error("RAS_DEPTH must be at least 1");
   end

   cf_kind_e          kind;
   logic              is_call;
   logic              is_ret;
   logic [PC_W-1:0]   jump_off;
   logic [PC_W-1:0]   seq_pc;
   logic [PC_W-1:0]   jump_tgt;
   logic              bht_taken;
   logic              btb_hit;
   logic [PC_W-1:0]   btb_tgt;
   logic [PC_W-1:0]   ras_top;
   logic [RAS_CW-1:0] ras_cnt;
   logic              ras_nonempty;
   logic [1:0]        unused_upd_lo;

   assign unused_upd_lo = upd_pc_i[1:0];

   fe_predecode #(.PC_W(PC_W)) u_predecode (
      .instr_i    (fetch_instr_i),
      .kind_o     (kind),
      .is_call_o  (is_call),
      .is_ret_o   (is_ret),
      .jump_off_o (jump_off)
   );

   // separate adder so direct jumps never wait for execute
   assign seq_pc   = fetch_pc_i + PC_W'(4);
   assign jump_tgt = fetch_pc_i + jump_off;

   fe_counter_table #(.ENTRIES(BHT_ENTRIES)) u_bht (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rd_idx_i    (fetch_pc_i[BHT_IW+1:2]),
      .rd_taken_o  (bht_taken),
      .upd_en_i    (upd_valid_i),
      .upd_idx_i   (upd_pc_i[BHT_IW+1:2]),
      .upd_taken_i (upd_taken_i)
   );

   fe_target_buffer #(.PC_W(PC_W), .ENTRIES(BTB_ENTRIES), .TAG_W(TAG_W)) u_btb (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lk_idx_i    (fetch_pc_i[BTB_IW+1:2]),
      .lk_tag_i    (fetch_pc_i[PC_W-1:BTB_IW+2]),
      .lk_hit_o    (btb_hit),
      .lk_target_o (btb_tgt),
      .wr_en_i     (upd_valid_i && upd_taken_i),
      .wr_idx_i    (upd_pc_i[BTB_IW+1:2]),
      .wr_tag_i    (upd_pc_i[PC_W-1:BTB_IW+2]),
      .wr_target_i (upd_target_i)
   );

   assign ras_nonempty = (ras_cnt != '0);

   fe_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (fetch_valid_i && is_call),
      .push_addr_i (seq_pc),
      .pop_i       (fetch_valid_i && is_ret && ras_nonempty),
      .top_o       (ras_top),
      .count_o     (ras_cnt)
   );

   always_comb begin
      pred_taken_o  = 1'b0;
      pred_target_o = seq_pc;
      if (fetch_valid_i) begin
         unique case (kind)
            CF_JUMP: begin
               pred_taken_o  = 1'b1;
               pred_target_o = jump_tgt;
            end
            CF_INDIRECT: begin
               if (is_ret && ras_nonempty) begin
                  pred_taken_o  = 1'b1;
                  pred_target_o = ras_top;
               end
            end
            CF_BRANCH: begin
               if (bht_taken && btb_hit) begin
                  pred_taken_o  = 1'b1;
                  pred_target_o = btb_tgt;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/fe_flow_predictor_chk.sv
module fe_flow_predictor_chk
   import fe_pred_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int RAS_DEPTH = 2,
   parameter int RAS_CW    = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              fetch_valid_i,
   input logic [PC_W-1:0]   fetch_pc_i,
   input logic [6:0]        opc_i,
   input logic [4:0]        rd_i,
   input logic [4:0]        rs1_i,
   input logic              pred_taken_o,
   input logic [PC_W-1:0]   pred_target_o,
   input logic [RAS_CW-1:0] ras_cnt_i
);

   logic call_seen;
   logic ret_seen;

   assign call_seen = fetch_valid_i && (opc_i == OPC_JAL || opc_i == OPC_JALR)
                      && (rd_i == 5'd1 || rd_i == 5'd5);
   assign ret_seen  = fetch_valid_i && opc_i == OPC_JALR && rd_i == 5'd0
                      && (rs1_i == 5'd1 || rs1_i == 5'd5);

   // R1
   a_r1_jump_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_valid_i && opc_i == OPC_JAL) |-> pred_taken_o);

   // R10
   a_r10_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pred_taken_o |-> (pred_target_o == fetch_pc_i + PC_W'(4)));

   // R9
   a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fetch_valid_i |-> !pred_taken_o);

   // R9
   a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fetch_valid_i |=> $stable(ras_cnt_i));

   // R2
   a_r2_call_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (call_seen && ras_cnt_i != RAS_CW'(RAS_DEPTH))
      |=> ras_cnt_i == RAS_CW'($past(ras_cnt_i) + 1'b1));

   // R4
   a_r4_empty_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_seen && ras_cnt_i == '0) |-> !pred_taken_o);

   // R3
   a_r3_ret_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_seen && ras_cnt_i != '0) |-> pred_taken_o);

   // R3
   a_r3_ret_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_seen && ras_cnt_i != '0) |=> ras_cnt_i == RAS_CW'($past(ras_cnt_i) - 1'b1));

   // R5
   a_r5_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ras_cnt_i <= RAS_CW'(RAS_DEPTH));

endmodule

bind fe_flow_predictor fe_flow_predictor_chk #(
   .PC_W      (PC_W),
   .RAS_DEPTH (RAS_DEPTH),
   .RAS_CW    (RAS_CW)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .fetch_valid_i (fetch_valid_i),
   .fetch_pc_i    (fetch_pc_i),
   .opc_i         (fetch_instr_i[6:0]),
   .rd_i          (fetch_instr_i[11:7]),
   .rs1_i         (fetch_instr_i[19:15]),
   .pred_taken_o  (pred_taken_o),
   .pred_target_o (pred_target_o),
   .ras_cnt_i     (ras_cnt)
);

// File: tb/fe_flow_predictor_test.sv
`timescale 1ns/1ps
module fe_flow_predictor_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fv = 1'b0;
   logic [31:0] fpc = '0;
   logic [31:0] finstr = 32'h0000_0013;
   logic        uv = 1'b0;
   logic [31:0] upc = '0;
   logic        utaken = 1'b0;
   logic [31:0] utgt = '0;
   logic        p_taken;
   logic [31:0] p_tgt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic        taken;
      logic [31:0] tgt;
      string       req;
   } exp_t;

   exp_t exp_q[$];

   always #10 clk = ~clk;

   fe_flow_predictor uut (
      .clk_i(clk), .rst_ni(rst_n),
      .fetch_valid_i(fv), .fetch_pc_i(fpc), .fetch_instr_i(finstr),
      .upd_valid_i(uv), .upd_pc_i(upc), .upd_taken_i(utaken), .upd_target_i(utgt),
      .pred_taken_o(p_taken), .pred_target_o(p_tgt)
   );

   function automatic logic [31:0] enc_jal(input logic [4:0] rd, input int off);
      logic [20:0] i;
      i = off[20:0];
      return {i[20], i[10:1], i[11], i[19:12], rd, 7'b1101111};
   endfunction

   function automatic logic [31:0] enc_jalr(input logic [4:0] rd, input logic [4:0] rs1);
      return {12'd0, rs1, 3'b000, rd, 7'b1100111};
   endfunction

   localparam logic [31:0] BEQ = {7'd0, 5'd2, 5'd1, 3'b000, 5'b01000, 7'b1100011};
   localparam logic [31:0] ADD = 32'h0020_81B3;

   // driver: one fetch per cycle, expectation queued for the monitor
   task automatic do_fetch(input logic [31:0] pc, input logic [31:0] ins, input logic valid,
                           input logic et, input logic [31:0] etgt, input string req);
      exp_t e;
      @(posedge clk); #1;
      fv = valid; fpc = pc; finstr = ins; uv = 1'b0;
      e.taken = et; e.tgt = etgt; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic do_update(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
      @(posedge clk); #1;
      fv = 1'b0; uv = 1'b1; upc = pc; utaken = tk; utgt = tgt;
   endtask

   // monitor: compares mid-cycle, away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         total++;
         if (p_taken !== e.taken || p_tgt !== e.tgt) begin
            bad++;
            $display("FAIL %s: taken=%0b target=%h expected taken=%0b target=%h",
                     e.req, p_taken, p_tgt, e.taken, e.tgt);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: finished=0 expected finished=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // reset state, idle fetch
      do_fetch(32'h0, ADD, 1'b0, 1'b0, 32'h4, "R9 reset idle");
      @(posedge clk); #1 rst_n = 1'b1;

      // R1 direct jumps, positive and negative offsets
      do_fetch(32'h1000, enc_jal(5'd0, 32'h100), 1'b1, 1'b1, 32'h1100, "R1 jump fwd");
      do_fetch(32'h2000, enc_jal(5'd0, -8), 1'b1, 1'b1, 32'h1FF8, "R1 jump back");

      // R4 return with empty stack
      do_fetch(32'h3000, enc_jalr(5'd0, 5'd1), 1'b1, 1'b0, 32'h3004, "R4 empty ret");

      // R2/R3 call then return
      do_fetch(32'h4000, enc_jal(5'd1, 32'h40), 1'b1, 1'b1, 32'h4040, "R2 call jump");
      do_fetch(32'h5000, enc_jalr(5'd0, 5'd1), 1'b1, 1'b1, 32'h4004, "R3 ret pop");
      do_fetch(32'h5010, enc_jalr(5'd0, 5'd1), 1'b1, 1'b0, 32'h5014, "R4 ret after pop");

      // R5 overflow drops the oldest
      do_fetch(32'h6000, enc_jalr(5'd1, 5'd10), 1'b1, 1'b0, 32'h6004, "R2 indirect call");
      do_fetch(32'h6100, enc_jal(5'd5, 8), 1'b1, 1'b1, 32'h6108, "R2 call x5");
      do_fetch(32'h6200, enc_jal(5'd1, 8), 1'b1, 1'b1, 32'h6208, "R5 third call");
      do_fetch(32'h6300, enc_jalr(5'd0, 5'd5), 1'b1, 1'b1, 32'h6204, "R5 ret newest");
      do_fetch(32'h6304, enc_jalr(5'd0, 5'd5), 1'b1, 1'b1, 32'h6104, "R5 ret second");
      do_fetch(32'h6308, enc_jalr(5'd0, 5'd1), 1'b1, 1'b0, 32'h630C, "R5 oldest dropped");

      // R9 idle call pushes nothing
      do_fetch(32'h7000, enc_jal(5'd1, 32'h80), 1'b0, 1'b0, 32'h7004, "R9 idle call");
      do_fetch(32'h7010, enc_jalr(5'd0, 5'd1), 1'b1, 1'b0, 32'h7014, "R9 stack untouched");

      // R10 other words
      do_fetch(32'h7100, ADD, 1'b1, 1'b0, 32'h7104, "R10 alu op");
      do_fetch(32'h7200, enc_jalr(5'd0, 5'd6), 1'b1, 1'b0, 32'h7204, "R10 plain indirect");

      // R6/R7 conditional branch training
      do_fetch(32'h8000, BEQ, 1'b1, 1'b0, 32'h8004, "R7 reset weak not-taken");
      do_update(32'h8000, 1'b1, 32'h8800);
      do_fetch(32'h8000, BEQ, 1'b1, 1'b1, 32'h8800, "R6 taken from target buffer");
      for (int k = 0; k < 3; k++) do_update(32'h8000, 1'b1, 32'h8800);
      do_update(32'h8000, 1'b0, 32'h0);
      do_fetch(32'h8000, BEQ, 1'b1, 1'b1, 32'h8800, "R7 saturated high");
      do_update(32'h8000, 1'b0, 32'h0);
      do_fetch(32'h8000, BEQ, 1'b1, 1'b0, 32'h8004, "R7 down to weak");
      for (int k = 0; k < 3; k++) do_update(32'h8000, 1'b0, 32'h0);
      do_update(32'h8000, 1'b1, 32'h8800);
      do_fetch(32'h8000, BEQ, 1'b1, 1'b0, 32'h8004, "R7 saturated low");
      do_update(32'h8000, 1'b1, 32'h8800);
      do_fetch(32'h8000, BEQ, 1'b1, 1'b1, 32'h8800, "R7 back to taken");

      // R8 shared counter, foreign tag
      do_fetch(32'h9000, BEQ, 1'b1, 1'b0, 32'h9004, "R8 tag mismatch");
      do_update(32'h8020, 1'b1, 32'h8A00);
      do_fetch(32'h8000, BEQ, 1'b1, 1'b0, 32'h8004, "R8 slot taken over");
      do_fetch(32'h8020, BEQ, 1'b1, 1'b1, 32'h8A00, "R6 new owner");

      @(posedge clk); #1 fv = 1'b0; uv = 1'b0;
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule